// File: doc/BRIEF.md
# Masked Multichannel Scan Sequencer

This block sits between a set of control registers and a conversion controller. It decides which of eight input channels is converted next. It issues a one-cycle start request that carries the chosen channel number, then waits for a done pulse from the controller before it moves on. Software supplies three settings: a per-channel enable mask, a starting channel and a scan mode. It also supplies a write strobe that marks a change to those settings, and a `go` command.

The scan opens at the starting channel, or at the first enabled channel above it. It climbs in ascending channel order, passes over disabled channels, and wraps from the top channel back to channel 0. A pass is finished when the next enabled channel would be the channel the pass opened with. There are three modes. Step mode converts one channel for each `go`. Once mode runs a single automatic pass. Loop mode repeats passes until the settings are written again. The search for the next enabled channel is a combinational rotating priority search that begins one channel above the current one.

Top module: `scan_sequencer`

## Requirements
- R1: When a scan is launched, the first channel converted is the starting channel if it is enabled. Otherwise it is the first enabled channel found by counting upward from the starting channel, wrapping from 7 to 0.
- R2: Each following conversion uses the next enabled channel above the previous one, in ascending order with wrap from 7 to 0. Disabled channels are never visited.
- R3: `conv_start` is high for exactly one cycle per request and only for a channel whose mask bit is 1. `conv_ch` holds that channel until the next request.
- R4: With mode 2'b00 (step), each `go` performs exactly one conversion, and the block returns to idle after its done pulse. The next `go` continues with the next enabled channel. `scan_done` is 1 after the step that closes a pass and 0 after every other step.
- R5: With mode 2'b01 (once), a single `go` converts every enabled channel exactly once. The block then returns to idle with `scan_done` set to 1.
- R6: With mode 2'b10 (loop), conversions continue without further `go` commands and `busy` stays 1. `scan_done` becomes 1 once the first full pass has completed.
- R7: With an all-zero mask, `go` starts no conversion and `busy` stays 0, in every mode.
- R8: Mode 2'b11 is reserved, and `go` has no effect in it.
- R9: A `cfg_wr` pulse drops `busy` on the next cycle and clears `scan_done`. It makes a later `conv_done` for the aborted request ineffective, and it resets the step position so the next step begins again at the first channel. `cfg_wr` takes priority over a `go` or a `conv_done` in the same cycle.
- R10: A `go` while busy is ignored, and a `conv_done` while idle is ignored.
- R11: After reset, `busy`, `conv_start` and `scan_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Settings were written; aborts any scan |
| cfg_mode | input | 2 | Scan mode: 00 step, 01 once, 10 loop, 11 reserved |
| cfg_mask | input | NCH | Channel enable mask, bit n enables channel n |
| cfg_start | input | CHW | Starting channel |
| go | input | 1 | Command: launch a scan or perform one step |
| conv_done | input | 1 | Conversion finished pulse from the controller |
| conv_start | output | 1 | One-cycle request to begin a conversion |
| conv_ch | output | CHW | Channel of the current or last request |
| busy | output | 1 | A scan or step is in progress |
| scan_done | output | 1 | A full pass over the enabled channels has completed |

## Verification
Three pairs of inputs can fall in the same cycle. An abort can coincide with the done pulse of a running conversion, or with a `go` command. A `go` can also arrive while a conversion is still pending. The bench provokes each pair by raising both inputs on the same falling edge. It judges the outcome one cycle later from `busy`, `conv_start` and `scan_done`, and then watches several more cycles to confirm that no stray request appears. The main sweeps cover every non-zero mask with every starting channel in once mode, plus a set of sparse and dense masks in step and loop modes. They compare each requested channel with a sequence computed arithmetically in the bench.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [1:0] {
    MODE_STEP = 2'b00,
    MODE_ONCE = 2'b01,
    MODE_LOOP = 2'b10,
    MODE_RSVD = 2'b11
  } scan_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_WAIT = 2'b10
  } seq_state_e;

endpackage

// File: rtl/scan_prio_search.sv
// Rotating priority search: lowest offset from base whose mask bit is set.
module scan_prio_search #(
  parameter int NCH = 8,
  parameter int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask,
  input  logic [CHW-1:0] base,
  output logic           hit,
  output logic [CHW-1:0] idx
);

  logic [CHW-1:0] cand;

  always_comb begin
    hit  = 1'b0;
    idx  = base;
    cand = base;
    // walk downward so the smallest offset is the last one to win
    for (int i = NCH - 1; i >= 0; i--) begin
      cand = base + CHW'(i);
      if (mask[cand]) begin
        hit = 1'b1;
        idx = cand;
      end
    end
  end

endmodule

// File: rtl/scan_step_ptr.sv
// Remembers where the next step-mode conversion resumes.
module scan_step_ptr #(
  parameter int CHW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           load,
  input  logic [CHW-1:0] nxt,
  output logic [CHW-1:0] ptr,
  output logic           vld
);

  logic [CHW-1:0] ptr_d;
  logic           vld_d;
  logic           ptr_en;

  always_comb begin
    ptr_en = clr | load;
    ptr_d  = ptr;
    vld_d  = vld;
    if (clr) begin
      vld_d = 1'b0;
    end else if (load) begin
      ptr_d = nxt;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      vld <= 1'b0;
    end else if (ptr_en) begin
      ptr <= ptr_d;
      vld <= vld_d;
    end
  end

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
  parameter int NCH = 8,
  parameter int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [1:0]     cfg_mode,
  input  logic [NCH-1:0] cfg_mask,
  input  logic [CHW-1:0] cfg_start,
  input  logic           go,
  input  logic           conv_done,
  output logic           conv_start,
  output logic [CHW-1:0] conv_ch,
  output logic           busy,
  output logic           scan_done
);
  import scan_pkg::*;

  localparam logic [CHW-1:0] ONE = CHW'(1);

  seq_state_e     state_q, state_d;
  logic [CHW-1:0] ch_q, ch_d;
  logic [CHW-1:0] first_q, first_d;
  logic           done_q, done_d;

  logic           first_hit, nxt_hit;
  logic [CHW-1:0] first_idx, nxt_idx, nxt_base;
  logic [CHW-1:0] ptr;
  logic           ptr_vld, ptr_load;
  logic           step_mode, mode_ok, resume, launch, wrap;
  scan_mode_e     mode;

  assign mode      = scan_mode_e'(cfg_mode);
  assign step_mode = (mode == MODE_STEP);
  assign mode_ok   = (mode != MODE_RSVD);
  assign nxt_base  = ch_q + ONE;

  scan_prio_search #(.NCH(NCH), .CHW(CHW)) u_first (
    .mask(cfg_mask), .base(cfg_start), .hit(first_hit), .idx(first_idx)
  );

  scan_prio_search #(.NCH(NCH), .CHW(CHW)) u_next (
    .mask(cfg_mask), .base(nxt_base), .hit(nxt_hit), .idx(nxt_idx)
  );

  scan_step_ptr #(.CHW(CHW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .load(ptr_load),
    .nxt(nxt_idx), .ptr(ptr), .vld(ptr_vld)
  );

  assign resume = step_mode & ptr_vld;
  assign launch = go & (state_q == ST_IDLE) & first_hit & mode_ok;
  assign wrap   = nxt_hit & (nxt_idx == first_q);

  // next-state logic
  always_comb begin
    state_d  = state_q;
    ch_d     = ch_q;
    first_d  = first_q;
    done_d   = done_q;
    ptr_load = 1'b0;
    if (cfg_wr) begin
      state_d = ST_IDLE;
      done_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (launch) begin
            state_d = ST_REQ;
            done_d  = 1'b0;
            ch_d    = resume ? ptr : first_idx;
            if (!resume) first_d = first_idx;
          end
        end
        ST_REQ: state_d = ST_WAIT;
        ST_WAIT: begin
          if (conv_done) begin
            if (wrap) done_d = 1'b1;
            unique case (mode)
              MODE_STEP: begin
                state_d  = ST_IDLE;
                ptr_load = 1'b1;
              end
              MODE_ONCE: begin
                if (wrap) begin
                  state_d = ST_IDLE;
                end else begin
                  state_d = ST_REQ;
                  ch_d    = nxt_idx;
                end
              end
              MODE_LOOP: begin
                state_d = ST_REQ;
                ch_d    = nxt_idx;
              end
              default: state_d = ST_IDLE;
            endcase
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      first_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      first_q <= first_d;
      done_q  <= done_d;
    end
  end

  assign conv_start = (state_q == ST_REQ);
  assign conv_ch    = ch_q;
  assign busy       = (state_q != ST_IDLE);
  assign scan_done  = done_q;

endmodule

// File: rtl/scan_sequencer_chk.sv
module scan_sequencer_chk #(
  parameter int NCH = 8,
  parameter int CHW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_wr,
  input logic [1:0]     cfg_mode,
  input logic [NCH-1:0] cfg_mask,
  input logic           go,
  input logic           conv_done,
  input logic           conv_start,
  input logic [CHW-1:0] conv_ch,
  input logic           busy,
  input logic           scan_done
);

  // R3: requests only name enabled channels
  assert_start_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> cfg_mask[conv_ch]);

  // R3: request is a single-cycle pulse
  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R9: abort drops busy on the next cycle and clears the pass flag
  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (!busy && !scan_done));

  // R4: in step mode a done pulse ends the step
  assert_step_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_start && conv_done && !cfg_wr && cfg_mode == 2'b00) |=> !busy);

  // R7: nothing starts with an empty mask
  assert_empty_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mask == '0) |-> !conv_start);

  // R10: a request only exists inside an active scan
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !conv_start);

  // R6: loop mode keeps running once a request has been issued
  assert_loop_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !cfg_wr && cfg_mode == 2'b10) |=> busy);

endmodule

bind scan_sequencer scan_sequencer_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
  .cfg_mask(cfg_mask), .go(go), .conv_done(conv_done),
  .conv_start(conv_start), .conv_ch(conv_ch), .busy(busy),
  .scan_done(scan_done)
);

// File: tb/scan_sequencer_test.sv
`timescale 1ns/1ps
module scan_sequencer_test;
  localparam int NCH = 8;
  localparam int CHW = 3;

  logic           clk;
  logic           rst_n;
  logic           cfg_wr;
  logic [1:0]     cfg_mode;
  logic [NCH-1:0] cfg_mask;
  logic [CHW-1:0] cfg_start;
  logic           go;
  logic           conv_done;
  logic           conv_start;
  logic [CHW-1:0] conv_ch;
  logic           busy;
  logic           scan_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  scan_sequencer #(.NCH(NCH), .CHW(CHW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .cfg_mask(cfg_mask), .cfg_start(cfg_start), .go(go),
    .conv_done(conv_done), .conv_start(conv_start), .conv_ch(conv_ch),
    .busy(busy), .scan_done(scan_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int first_en(input int mask, input int start);
    for (int i = 0; i < NCH; i++) begin
      if (mask[(start + i) % NCH]) return (start + i) % NCH;
    end
    return -1;
  endfunction

  function automatic int next_en(input int mask, input int ch);
    return first_en(mask, (ch + 1) % NCH);
  endfunction

  function automatic int popc(input int mask);
    int n = 0;
    for (int i = 0; i < NCH; i++) n += mask[i];
    return n;
  endfunction

  task automatic set_cfg(input int mode, input int mask, input int start);
    @(negedge clk);
    cfg_mode  = 2'(mode);
    cfg_mask  = NCH'(mask);
    cfg_start = CHW'(start);
    cfg_wr    = 1'b1;
    @(negedge clk);
    cfg_wr    = 1'b0;
  endtask

  task automatic pulse_go();
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic wait_start(output int ch, output bit got);
    ch  = -1;
    got = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (conv_start) begin
        got = 1'b1;
        ch  = int'(conv_ch);
        break;
      end
      @(negedge clk);
    end
  endtask

  // serve a pending conversion; checks pulse width and held channel
  task automatic finish_conv(input int ch, input bit deep);
    @(negedge clk);
    if (deep) chk(!conv_start && int'(conv_ch) == ch, "R3", int'(conv_ch), ch);
    @(negedge clk);
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic expect_quiet(input string req, input int cycles);
    bit seen = 0;
    for (int k = 0; k < cycles; k++) begin
      if (conv_start || busy) seen = 1;
      @(negedge clk);
    end
    chk(!seen, req, int'(seen), 0);
  endtask

  int ch;
  bit got;
  int exp_ch;
  int n;
  int sparse[6] = '{8'h01, 8'h80, 8'hA5, 8'h5A, 8'hFF, 8'h11};

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_mode = 2'b00; cfg_mask = '0;
    cfg_start = '0; go = 1'b0; conv_done = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!busy && !conv_start && !scan_done, "R11", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !scan_done, "R11", int'(scan_done), 0);

    // R1 R2 R5: once mode over every non-zero mask and every start
    for (int m = 1; m < 256; m++) begin
      for (int s = 0; s < NCH; s++) begin
        set_cfg(1, m, s);
        pulse_go();
        exp_ch = first_en(m, s);
        n = popc(m);
        for (int k = 0; k < n; k++) begin
          wait_start(ch, got);
          chk(got && ch == exp_ch, (k == 0) ? "R1" : "R2", ch, exp_ch);
          finish_conv(exp_ch, (m == 8'hA5));
          exp_ch = next_en(m, exp_ch);
        end
        chk(!busy && scan_done, "R5", {30'd0, busy, scan_done}, 1);
      end
    end

    // R4: step mode, two passes plus one
    foreach (sparse[i]) begin
      for (int s = 0; s < NCH; s++) begin
        set_cfg(0, sparse[i], s);
        exp_ch = first_en(sparse[i], s);
        n = popc(sparse[i]);
        for (int k = 0; k < 2 * n + 1; k++) begin
          pulse_go();
          wait_start(ch, got);
          chk(got && ch == exp_ch, "R4", ch, exp_ch);
          finish_conv(exp_ch, 1'b0);
          chk(!busy && scan_done == ((k % n) == n - 1), "R4",
              {30'd0, busy, scan_done}, int'((k % n) == n - 1));
          exp_ch = next_en(sparse[i], exp_ch);
        end
      end
    end

    // R6: loop mode, then R9 abort while a request is pending
    foreach (sparse[i]) begin
      for (int s = 0; s < NCH; s += 3) begin
        set_cfg(2, sparse[i], s);
        pulse_go();
        exp_ch = first_en(sparse[i], s);
        n = popc(sparse[i]);
        for (int k = 0; k < 2 * n + 1; k++) begin
          wait_start(ch, got);
          chk(got && ch == exp_ch, "R6", ch, exp_ch);
          finish_conv(exp_ch, 1'b0);
          chk(busy && scan_done == (k >= n - 1), "R6",
              {30'd0, busy, scan_done}, int'(k >= n - 1) + 2);
          exp_ch = next_en(sparse[i], exp_ch);
        end
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk(!busy && !scan_done, "R9", {30'd0, busy, scan_done}, 0);
        expect_quiet("R9", 6);
      end
    end

    // R7: empty mask in every mode
    for (int md = 0; md < 3; md++) begin
      set_cfg(md, 0, md);
      pulse_go();
      expect_quiet("R7", 6);
    end

    // R8: reserved mode ignores go
    set_cfg(3, 8'hFF, 0);
    pulse_go();
    expect_quiet("R8", 6);

    // R9: abort coincides with conv_done
    set_cfg(1, 8'hFF, 0);
    pulse_go();
    wait_start(ch, got);
    @(negedge clk); @(negedge clk);
    conv_done = 1'b1; cfg_wr = 1'b1;
    @(negedge clk);
    conv_done = 1'b0; cfg_wr = 1'b0;
    chk(!busy && !scan_done, "R9", int'(busy), 0);
    expect_quiet("R9", 6);

    // R9: late done after an abort is ignored
    set_cfg(1, 8'hFF, 4);
    pulse_go();
    wait_start(ch, got);
    @(negedge clk);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    expect_quiet("R9", 6);

    // R9: go together with cfg_wr is dropped
    cfg_mode = 2'b01; cfg_mask = 8'h0F; cfg_start = 3'd1;
    cfg_wr = 1'b1; go = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; go = 1'b0;
    expect_quiet("R9", 6);

    // R9: rewrite forgets the step position
    set_cfg(0, 8'hFF, 2);
    pulse_go(); wait_start(ch, got); finish_conv(2, 1'b0);
    pulse_go(); wait_start(ch, got);
    chk(got && ch == 3, "R4", ch, 3);
    finish_conv(3, 1'b0);
    set_cfg(0, 8'hFF, 2);
    pulse_go(); wait_start(ch, got);
    chk(got && ch == 2, "R9", ch, 2);
    finish_conv(2, 1'b0);

    // R10: go while busy and done while idle are ignored
    set_cfg(1, 8'h03, 0);
    pulse_go();
    wait_start(ch, got);
    chk(got && ch == 0, "R10", ch, 0);
    @(negedge clk);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    wait_start(ch, got);
    chk(got && ch == 1, "R10", ch, 1);
    finish_conv(1, 1'b0);
    chk(!busy && scan_done, "R10", int'(busy), 0);
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    expect_quiet("R10", 6);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule